// File: doc/BRIEF.md
# Clock Status Interrupt Flag Unit

This block gathers the interrupt sources of a clock and reset generator and presents them to a processor through a small register window. There are three sources. The first is a periodic timeout from a built-in tick counter. The second is any change in the PLL lock indication. The third is any change in the self-clock-mode indication. Each source owns a sticky flag that software clears by writing a 1, and a local enable bit. One combined interrupt request leaves the block.

The tick period is a power of two of the input clock, selected by a 4-bit field. A run-in-stop bit decides whether the counter keeps going while the chip is in pseudo-stop. If it keeps going, the tick can serve as a periodic wakeup source. The lock, self-clock-mode and clock-loss inputs come from other clock domains. Each passes through a two-flop synchronizer. The self-clock-mode status is then compared with its previous value, so a flag is raised on entry and on exit. When the clock monitor is enabled, loss of the external clock forces the self-clock-mode status high. Register map: address 0 is CONFIG, with select in bits [3:0], run-in-stop in bit 4 and monitor enable in bit 5. Address 1 is IEN, with the tick, lock and self-clock enables in bits 0, 1 and 2. Address 2 is FLAGS, using the same bit order as IEN. Address 3 reads zero.

Top module: `cgen_irq_unit`

## Requirements
- R1: After synchronous reset, all three registers read 0 and irq_o is 0.
- R2: With CONFIG[3:0]=s and the counter advancing, FLAGS[0] sets exactly 2^(10+s) clocks after the CONFIG write, and not one clock earlier.
- R3: Any write to CONFIG restarts the tick counter from zero, so the next tick comes a full period after that write.
- R4: While pseudo_stop_i is 1 and CONFIG[4] is 0, the tick counter holds its value. With CONFIG[4]=1 it keeps counting through pseudo-stop.
- R5: Writing FLAGS clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R6: A flag sets whatever its enable is. Its contribution to irq_o is masked while its IEN bit is 0.
- R7: FLAGS[1] sets on both a rising and a falling change of lock_async_i, on the third clock edge after the change.
- R8: FLAGS[2] sets on both entry into self-clock mode (scm_async_i rising) and exit from it (falling), on the third clock edge after the change.
- R9: With CONFIG[5]=1, clk_lost_async_i=1 forces the self-clock status to 1 and so raises FLAGS[2]. With CONFIG[5]=0 the clock-loss input has no effect.
- R10: irq_o is the OR over the three sources of flag AND enable.
- R11: When a set event and a write-1 clear of the same flag fall on the same clock edge, the flag ends up set.
- R12: Status inputs that are already high during reset produce no flag after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Combinational read data |
| pseudo_stop_i | input | 1 | Chip is in pseudo-stop |
| lock_async_i | input | 1 | PLL lock status, asynchronous |
| scm_async_i | input | 1 | Self-clock-mode status, asynchronous |
| clk_lost_async_i | input | 1 | External clock loss indication, asynchronous |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a set event and a write-1 clear landing on exactly the same clock edge. The bench counts the synchronizer and edge-detector stages from its own model. It toggles the lock input and places the FLAGS write two negative edges later, so the clear strobe meets the third edge. The tick-period sweep over select values 0 to 3 checks the flag one clock before the expected edge and again at it. The pseudo-stop test splits the 1024-clock period around a long frozen interval.

// File: rtl/cgen_irq_pkg.sv
package cgen_irq_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int SEL_W    = 4;
    localparam int BASE_EXP = 10;
    localparam int NSRC     = 3;
    localparam int CNT_W    = BASE_EXP + (1 << SEL_W);

    // source positions inside IEN and FLAGS
    localparam int SRC_TICK = 0;
    localparam int SRC_LOCK = 1;
    localparam int SRC_SCM  = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CFG = 2'd0,
        ADDR_IEN = 2'd1,
        ADDR_FLG = 2'd2,
        ADDR_RSV = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             mon_en;
        logic             run_in_stop;
        logic [SEL_W-1:0] sel;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    function automatic logic [CNT_W-1:0] last_count(input logic [SEL_W-1:0] sel);
        last_count = (CNT_W'(1) << (BASE_EXP + int'(sel))) - CNT_W'(1);
    endfunction

endpackage

// File: rtl/rti_tick_gen.sv
module rti_tick_gen
    import cgen_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             advance,
    input  logic [SEL_W-1:0] sel,
    output logic             tick,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == last_count(sel));
    assign tick   = advance && at_end && !restart;
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/stat_sync.sv
module stat_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;

    // free-running so the stages are filled while reset is held
    always_ff @(posedge clk) begin
        meta_q <= async_i;
        sync_q <= meta_q;
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/stat_change_det.sv
module stat_change_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] change_o
);

    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            // reset loads the present level, so no edge is seen after reset
            prev_q[i] <= level_i[i];
        end
        assign change_o[i] = !rst && (level_i[i] != prev_q[i]);
    end

endmodule

// File: rtl/cgen_irq_unit.sv
module cgen_irq_unit
    import cgen_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pseudo_stop_i,
    input  logic              lock_async_i,
    input  logic              scm_async_i,
    input  logic              clk_lost_async_i,
    output logic              irq_o
);

    cfg_t            cfg_q;
    logic [NSRC-1:0] ien_q;
    logic [NSRC-1:0] flags_q;
    logic [NSRC-1:0] set_evt;
    logic [NSRC-1:0] clr_req;

    logic             cfg_wr;
    logic             flg_wr;
    logic             tick_evt;
    logic [CNT_W-1:0] tick_cnt;
    logic             advance;

    logic [2:0] stat_s;   // {clk_lost, scm, lock}
    logic [1:0] level;    // {scm status, lock status}
    logic [1:0] change;   // {scm change, lock change}

    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[DATA_W-1:CFG_W];

    assign cfg_wr  = wr_en && (wr_addr == ADDR_CFG);
    assign flg_wr  = wr_en && (wr_addr == ADDR_FLG);
    assign advance = !pseudo_stop_i || cfg_q.run_in_stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            ien_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CFG) cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
            if (wr_addr == ADDR_IEN) ien_q <= wr_data[NSRC-1:0];
        end
    end

    rti_tick_gen u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (cfg_wr),
        .advance (advance),
        .sel     (cfg_q.sel),
        .tick    (tick_evt),
        .cnt_o   (tick_cnt)
    );

    stat_sync #(.N(3)) u_sync (
        .clk     (clk),
        .async_i ({clk_lost_async_i, scm_async_i, lock_async_i}),
        .sync_o  (stat_s)
    );

    assign level[0] = stat_s[0];
    assign level[1] = stat_s[1] || (cfg_q.mon_en && stat_s[2]);

    stat_change_det #(.N(2)) u_det (
        .clk      (clk),
        .rst      (rst),
        .level_i  (level),
        .change_o (change)
    );

    assign set_evt[SRC_TICK] = tick_evt;
    assign set_evt[SRC_LOCK] = change[0];
    assign set_evt[SRC_SCM]  = change[1];
    assign clr_req           = flg_wr ? wr_data[NSRC-1:0] : '0;

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             flags_q[i] <= 1'b0;
            else if (set_evt[i]) flags_q[i] <= 1'b1;
            else if (clr_req[i]) flags_q[i] <= 1'b0;
        end
    end

    assign irq_o = |(flags_q & ien_q);

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            ADDR_CFG: rd_data[CFG_W-1:0] = cfg_q;
            ADDR_IEN: rd_data[NSRC-1:0]  = ien_q;
            ADDR_FLG: rd_data[NSRC-1:0]  = flags_q;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cgen_irq_chk.sv
module cgen_irq_chk
    import cgen_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             flg_wr,
    input logic [NSRC-1:0]  clr_bits,
    input logic             pseudo_stop,
    input logic             run_in_stop,
    input logic             restart,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [1:0]       change,
    input logic [NSRC-1:0]  flags,
    input logic [NSRC-1:0]  ien,
    input logic             irq
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (flags == '0) && (ien == '0));

    // R4
    frozen_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (pseudo_stop && !run_in_stop && !restart) |=> $stable(cnt));

    // R5
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (flg_wr && clr_bits[SRC_TICK] && !tick) |=> !flags[SRC_TICK]);

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[SRC_TICK] && !(flg_wr && clr_bits[SRC_TICK])) |=> flags[SRC_TICK]);

    // R11
    tick_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> flags[SRC_TICK]);

    // R7
    lock_change_chk: assert property (@(posedge clk) disable iff (rst)
        change[0] |=> flags[SRC_LOCK]);

    // R8
    scm_change_chk: assert property (@(posedge clk) disable iff (rst)
        change[1] |=> flags[SRC_SCM]);

    // R6
    masked_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> !irq);

endmodule

bind cgen_irq_unit cgen_irq_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .flg_wr      (flg_wr),
    .clr_bits    (wr_data[2:0]),
    .pseudo_stop (pseudo_stop_i),
    .run_in_stop (cfg_q.run_in_stop),
    .restart     (cfg_wr),
    .tick        (tick_evt),
    .cnt         (tick_cnt),
    .change      (change),
    .flags       (flags_q),
    .ien         (ien_q),
    .irq         (irq_o)
);

// File: tb/cgen_irq_unit_tb_top.sv
`timescale 1ns/1ps
module cgen_irq_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pseudo_stop_i = 1'b0;
    logic       lock_async_i = 1'b1;
    logic       scm_async_i = 1'b1;
    logic       clk_lost_async_i = 1'b0;
    logic       irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cgen_irq_unit dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pseudo_stop_i(pseudo_stop_i),
        .lock_async_i(lock_async_i), .scm_async_i(scm_async_i),
        .clk_lost_async_i(clk_lost_async_i), .irq_o(irq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    function automatic int flag_bit(input int b);
        logic [7:0] v;
        rd_addr = 2'd2;
        v = rd_data;
        return int'(v[b]);
    endfunction

    task automatic fbit(input int b, output int v);
        logic [7:0] d;
        rd(2'd2, d);
        v = int'(d[b]);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        int v;
        step(6);
        rst = 1'b0;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            check("R1 register reads zero", int'(d), 0);
        end
        check("R1 irq low", int'(irq_o), 0);
        // R12 inputs high through reset give no flag
        step(10);
        rd(2'd2, d);
        check("R12 no spurious flags", int'(d), 0);

        // R2 sweep of select values
        for (int s = 0; s < 4; s++) begin
            wr(2'd2, 8'h07);
            wr(2'd0, 8'(s));
            step((1 << (10 + s)) - 1);
            fbit(0, v); check("R2 tick flag one clock early", v, 0);
            step(1);
            fbit(0, v); check("R2 tick flag at period", v, 1);
        end

        // R3 restart on config write
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h07);
        step(500);
        wr(2'd0, 8'h00);
        step(1023);
        fbit(0, v); check("R3 no tick from old count", v, 0);
        step(1);
        fbit(0, v); check("R3 tick one period after rewrite", v, 1);

        // R4 pseudo-stop freeze
        wr(2'd2, 8'h07);
        wr(2'd0, 8'h00);
        step(100);
        pseudo_stop_i = 1'b1;
        step(2000);
        fbit(0, v); check("R4 frozen in pseudo-stop", v, 0);
        pseudo_stop_i = 1'b0;
        step(923);
        fbit(0, v); check("R4 resumed count short", v, 0);
        step(1);
        fbit(0, v); check("R4 resumed count complete", v, 1);
        wr(2'd2, 8'h07);
        wr(2'd0, 8'h10);
        pseudo_stop_i = 1'b1;
        step(1023);
        fbit(0, v); check("R4 run-in-stop short", v, 0);
        step(1);
        fbit(0, v); check("R4 run-in-stop ticks", v, 1);
        pseudo_stop_i = 1'b0;

        // R5 write-1-clear
        wr(2'd2, 8'h06);
        fbit(0, v); check("R5 zero bit leaves flag", v, 1);
        wr(2'd2, 8'h01);
        fbit(0, v); check("R5 one bit clears flag", v, 0);

        // R6 flag sets while masked
        step(1030);
        fbit(0, v); check("R6 flag sets with enable off", v, 1);
        check("R6 irq masked", int'(irq_o), 0);
        wr(2'd1, 8'h01);
        check("R6 irq when enabled", int'(irq_o), 1);
        wr(2'd1, 8'h00);

        // R7 lock change both directions
        wr(2'd1, 8'h02);
        wr(2'd2, 8'h07);
        check("R7 irq idle", int'(irq_o), 0);
        lock_async_i = 1'b0;
        step(2);
        fbit(1, v); check("R7 falling lock early", v, 0);
        step(1);
        fbit(1, v); check("R7 falling lock flag", v, 1);
        check("R7 irq on lock", int'(irq_o), 1);
        wr(2'd2, 8'h02);
        lock_async_i = 1'b1;
        step(2);
        fbit(1, v); check("R7 rising lock early", v, 0);
        step(1);
        fbit(1, v); check("R7 rising lock flag", v, 1);

        // R11 set and clear on the same edge
        lock_async_i = 1'b0;
        step(2);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h02;
        step(1);
        wr_en = 1'b0;
        fbit(1, v); check("R11 set wins over clear", v, 1);
        wr(2'd2, 8'h02);
        fbit(1, v); check("R11 plain clear afterwards", v, 0);
        wr(2'd1, 8'h00);

        // R8 self-clock-mode entry and exit
        scm_async_i = 1'b0;
        step(3);
        fbit(2, v); check("R8 exit flag", v, 1);
        wr(2'd2, 8'h04);
        scm_async_i = 1'b1;
        step(2);
        fbit(2, v); check("R8 entry early", v, 0);
        step(1);
        fbit(2, v); check("R8 entry flag", v, 1);
        scm_async_i = 1'b0;
        step(5);

        // R9 clock loss gated by monitor enable
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h07);
        clk_lost_async_i = 1'b1;
        step(5);
        fbit(2, v); check("R9 loss ignored with monitor off", v, 0);
        wr(2'd0, 8'h20);
        fbit(2, v); check("R9 before status update", v, 0);
        step(1);
        fbit(2, v); check("R9 monitor on forces entry", v, 1);
        wr(2'd2, 8'h04);
        clk_lost_async_i = 1'b0;
        step(3);
        fbit(2, v); check("R9 clock return exits", v, 1);
        wr(2'd0, 8'h00);

        // R10 combined request sweep
        step(1100);
        lock_async_i = ~lock_async_i;
        scm_async_i  = ~scm_async_i;
        step(5);
        rd(2'd2, d);
        check("R10 all flags set", int'(d), 7);
        for (int e = 0; e < 8; e++) begin
            wr(2'd1, 8'(e));
            check("R10 irq all flags", int'(irq_o), int'(e != 0));
        end
        wr(2'd2, 8'h05);
        for (int e = 0; e < 8; e++) begin
            wr(2'd1, 8'(e));
            check("R10 irq lock only", int'(irq_o), (e >> 1) & 1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule